// File: doc/BRIEF.md
# Subframe Chip-Counter Timing Generator

This block produces the periodic timing strobes that keep a modem's physical layer in step. A chip counter advances on each system-clock cycle where a chip-rate enable pulse is high. It runs through one physical subframe of 2880 chips and then wraps. One chip is one eighth of a bit on the line, so a subframe carries 360 bits, or 45 bytes of eight bits each.

The counter value is decoded into registered single-cycle strobes:
- a bit strobe;
- a byte strobe;
- a subframe-start strobe;
- two early-warning strobes, which fire one chip before a subframe boundary and one chip before a byte boundary.

Downstream transmit and receive logic uses these strobes to align its bit, byte and slot processing. It reads the exposed counter to locate positions inside the subframe.

One generator serves both directions. A transmit/receive select input may change at any time and never disturbs the count, so both directions keep identical relative timing. The select is registered alongside the strobes. Consumers therefore see which direction a given strobe belongs to in the same cycle as the strobe.

Top module: `subframe_timer`

## Requirements
- R1: On a clock edge where `chip_en` is 1, `chip_cnt` advances by one. From the value 2879 it goes to 0 instead, so it never leaves the range 0..2879.
- R2: On a clock edge where `chip_en` is 0, `chip_cnt` keeps its value.
- R3: `bit_stb` is 1 in the cycle after an enabled edge exactly when the counter value before that edge was a multiple of 8.
- R4: `byte_stb` is 1 in the cycle after an enabled edge exactly when the counter value before that edge was a multiple of 64 (0, 64, ... 2816). Every byte strobe coincides with a bit strobe.
- R5: `frame_stb` is 1 in the cycle after an enabled edge exactly when the counter value before that edge was 0.
- R6: `pre_frame_stb` is 1 in the cycle after an enabled edge exactly when the counter value before that edge was 2879.
- R7: `pre_byte_stb` is 1 in the cycle after an enabled edge exactly when the counter value before that edge left remainder 63 modulo 64 (63, 127, ... 2815, 2879).
- R8: The strobes are registered. Each one lasts a single clock cycle, and all of them are 0 in any cycle that follows an edge where `chip_en` was 0.
- R9: Changes of `tx_mode` have no effect on `chip_cnt` or on any strobe. `tx_active` equals the value `tx_mode` had at the previous clock edge.
- R10: While `rst_n` is low, `chip_cnt` is 0 and all strobes and `tx_active` are 0. The reset is asserted asynchronously and released in step with the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| chip_en | input | 1 | Chip-rate enable, one pulse per chip |
| tx_mode | input | 1 | 1 selects transmit, 0 selects receive |
| chip_cnt | output | 12 | Current chip position inside the subframe |
| bit_stb | output | 1 | Bit boundary strobe |
| byte_stb | output | 1 | Byte boundary strobe |
| frame_stb | output | 1 | Subframe start strobe |
| pre_frame_stb | output | 1 | Strobe one chip before the subframe wraps |
| pre_byte_stb | output | 1 | Strobe one chip before each byte boundary |
| tx_active | output | 1 | Direction flag registered with the strobes |

## Verification
The properties assume `chip_en` and `tx_mode` are clean synchronous levels that are valid at each rising edge. They make no assumption about how dense the enable pulses are. The bench drives both inputs only on falling edges. It draws the enable with varying densities, from sparse to always on, and toggles the direction select at random, including right at the wrap. Directed phases hold the enable high through several wraps and apply a reset in the middle of a run.

// File: rtl/subframe_timer_pkg.sv
package subframe_timer_pkg;

  typedef struct packed {
    logic bit_s;
    logic byte_s;
    logic frame_s;
    logic pre_frame_s;
    logic pre_byte_s;
  } strobe_t;

  localparam int STROBE_N = $bits(strobe_t);

  function automatic bit is_pow2(input int val);
    return (val > 1) && ((val & (val - 1)) == 0);
  endfunction

endpackage

// File: rtl/subframe_rst_sync.sv
module subframe_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_q_n = sync_q[STAGES-1];

endmodule

// File: rtl/subframe_chip_counter.sv
module subframe_chip_counter #(
  parameter int CHIPS_PER_FRAME = 2880,
  parameter int CNT_W           = 12
) (
  input  logic             clk,
  input  logic             rst_q_n,
  input  logic             step,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(CHIPS_PER_FRAME - 1);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             wrap;

  // next-state logic
  always_comb begin
    wrap  = (cnt_q == LAST);
    cnt_d = cnt_q;
    if (step) begin
      cnt_d = wrap ? '0 : (cnt_q + ONE);
    end
  end

  // state register
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/subframe_strobe_decode.sv
module subframe_strobe_decode
  import subframe_timer_pkg::*;
#(
  parameter int CHIPS_PER_FRAME = 2880,
  parameter int CHIPS_PER_BIT   = 8,
  parameter int BITS_PER_BYTE   = 8,
  parameter int CNT_W           = 12
) (
  input  logic [CNT_W-1:0] cnt,
  output strobe_t          dec
);

  localparam int CHIPS_PER_BYTE = CHIPS_PER_BIT * BITS_PER_BYTE;
  localparam logic [CNT_W-1:0] LAST   = CNT_W'(CHIPS_PER_FRAME - 1);
  localparam logic [CNT_W-1:0] BIT_L  = CNT_W'(CHIPS_PER_BIT);
  localparam logic [CNT_W-1:0] BYTE_L = CNT_W'(CHIPS_PER_BYTE);
  localparam logic [CNT_W-1:0] BYTE_M = CNT_W'(CHIPS_PER_BYTE - 1);

  logic on_bit;
  logic on_byte;
  logic before_byte;

  // bit boundary: low bits when the period is a power of two, remainder otherwise
  generate
    if (is_pow2(CHIPS_PER_BIT)) begin : g_bit_pow2
      localparam int LB = $clog2(CHIPS_PER_BIT);
      assign on_bit = (cnt[LB-1:0] == '0);
    end else begin : g_bit_mod
      assign on_bit = ((cnt % BIT_L) == '0);
    end
  endgenerate

  // byte boundary and the chip before it
  generate
    if (is_pow2(CHIPS_PER_BYTE)) begin : g_byte_pow2
      localparam int LY = $clog2(CHIPS_PER_BYTE);
      assign on_byte     = (cnt[LY-1:0] == '0);
      assign before_byte = &cnt[LY-1:0];
    end else begin : g_byte_mod
      assign on_byte     = ((cnt % BYTE_L) == '0);
      assign before_byte = ((cnt % BYTE_L) == BYTE_M);
    end
  endgenerate

  always_comb begin
    dec.bit_s       = on_bit;
    dec.byte_s      = on_byte;
    dec.frame_s     = (cnt == '0);
    dec.pre_frame_s = (cnt == LAST);
    dec.pre_byte_s  = before_byte || (cnt == LAST);
  end

endmodule

// File: rtl/subframe_strobe_reg.sv
module subframe_strobe_reg
  import subframe_timer_pkg::*;
(
  input  logic    clk,
  input  logic    rst_q_n,
  input  logic    step,
  input  strobe_t dec,
  input  logic    mode_in,
  output strobe_t stb,
  output logic    mode_out
);

  strobe_t stb_q;
  strobe_t stb_d;
  logic    mode_q;

  // strobes are qualified by the chip enable
  always_comb begin
    stb_d = '0;
    if (step) begin
      stb_d = dec;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      stb_q  <= '0;
      mode_q <= 1'b0;
    end else begin
      stb_q  <= stb_d;
      mode_q <= mode_in;
    end
  end

  assign stb      = stb_q;
  assign mode_out = mode_q;

endmodule

// File: rtl/subframe_timer.sv
module subframe_timer
  import subframe_timer_pkg::*;
#(
  parameter int CHIPS_PER_FRAME = 2880,
  parameter int CHIPS_PER_BIT   = 8,
  parameter int BITS_PER_BYTE   = 8,
  parameter int CNT_W           = 12,
  parameter int RST_STAGES      = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chip_en,
  input  logic             tx_mode,
  output logic [CNT_W-1:0] chip_cnt,
  output logic             bit_stb,
  output logic             byte_stb,
  output logic             frame_stb,
  output logic             pre_frame_stb,
  output logic             pre_byte_stb,
  output logic             tx_active
);

  logic    rst_q_n;
  strobe_t dec;
  strobe_t stb;

  subframe_rst_sync #(
    .STAGES(RST_STAGES)
  ) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_q_n(rst_q_n)
  );

  subframe_chip_counter #(
    .CHIPS_PER_FRAME(CHIPS_PER_FRAME),
    .CNT_W          (CNT_W)
  ) u_cnt (
    .clk    (clk),
    .rst_q_n(rst_q_n),
    .step   (chip_en),
    .cnt    (chip_cnt)
  );

  subframe_strobe_decode #(
    .CHIPS_PER_FRAME(CHIPS_PER_FRAME),
    .CHIPS_PER_BIT  (CHIPS_PER_BIT),
    .BITS_PER_BYTE  (BITS_PER_BYTE),
    .CNT_W          (CNT_W)
  ) u_dec (
    .cnt(chip_cnt),
    .dec(dec)
  );

  subframe_strobe_reg u_stb (
    .clk     (clk),
    .rst_q_n (rst_q_n),
    .step    (chip_en),
    .dec     (dec),
    .mode_in (tx_mode),
    .stb     (stb),
    .mode_out(tx_active)
  );

  assign bit_stb       = stb.bit_s;
  assign byte_stb      = stb.byte_s;
  assign frame_stb     = stb.frame_s;
  assign pre_frame_stb = stb.pre_frame_s;
  assign pre_byte_stb  = stb.pre_byte_s;

endmodule

// File: rtl/subframe_timer_chk.sv
module subframe_timer_chk #(
  parameter int CHIPS_PER_FRAME = 2880,
  parameter int CNT_W           = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_q_n,
  input logic             chip_en,
  input logic             tx_mode,
  input logic [CNT_W-1:0] chip_cnt,
  input logic             bit_stb,
  input logic             byte_stb,
  input logic             frame_stb,
  input logic             pre_frame_stb,
  input logic             pre_byte_stb,
  input logic             tx_active
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(CHIPS_PER_FRAME - 1);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  // R1
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (chip_en && chip_cnt == LAST) |=> (chip_cnt == '0));

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (chip_en && chip_cnt != LAST) |=> (chip_cnt == $past(chip_cnt) + ONE));

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    chip_cnt <= LAST);

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !chip_en |=> $stable(chip_cnt));

  // R8
  stb_idle_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !chip_en |=> !(bit_stb || byte_stb || frame_stb || pre_frame_stb || pre_byte_stb));

  // R4
  byte_on_bit_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    byte_stb |-> bit_stb);

  // R5
  frame_pos_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    frame_stb |-> (chip_cnt == ONE) && byte_stb);

  // R6
  pre_frame_pos_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    pre_frame_stb |-> (chip_cnt == '0) && pre_byte_stb);

  // R9
  mode_follow_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    1'b1 |=> (tx_active == $past(tx_mode)));

  // R10
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_state_chk: assert (chip_cnt == '0 || !rst_q_n);
    end
  end

endmodule

bind subframe_timer subframe_timer_chk #(
  .CHIPS_PER_FRAME(CHIPS_PER_FRAME),
  .CNT_W          (CNT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rst_q_n      (rst_q_n),
  .chip_en      (chip_en),
  .tx_mode      (tx_mode),
  .chip_cnt     (chip_cnt),
  .bit_stb      (bit_stb),
  .byte_stb     (byte_stb),
  .frame_stb    (frame_stb),
  .pre_frame_stb(pre_frame_stb),
  .pre_byte_stb (pre_byte_stb),
  .tx_active    (tx_active)
);

// File: tb/subframe_timer_bench.sv
`timescale 1ns/1ps
module subframe_timer_bench;

  localparam int FRAME = 2880;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        chip_en;
  logic        tx_mode;
  logic [11:0] chip_cnt;
  logic        bit_stb, byte_stb, frame_stb, pre_frame_stb, pre_byte_stb, tx_active;

  int total = 0;
  int bad   = 0;
  int m_cnt = 0;
  logic [4:0] m_stb = '0;
  logic m_mode = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  subframe_timer u_subframe_timer (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .tx_mode(tx_mode),
    .chip_cnt(chip_cnt), .bit_stb(bit_stb), .byte_stb(byte_stb),
    .frame_stb(frame_stb), .pre_frame_stb(pre_frame_stb),
    .pre_byte_stb(pre_byte_stb), .tx_active(tx_active)
  );

  // expected strobes {bit, byte, frame, pre_frame, pre_byte} for a counter value
  function automatic logic [4:0] exp_dec(input int c);
    logic [4:0] r;
    r[4] = (c % 8) == 0;                      // R3
    r[3] = (c % 64) == 0;                     // R4
    r[2] = (c == 0);                          // R5
    r[1] = (c == FRAME - 1);                  // R6
    r[0] = ((c % 64) == 63) || (c == FRAME - 1); // R7
    return r;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at time %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    check({tag, " R1/R2 count"}, int'(chip_cnt), m_cnt);
    check({tag, " R3 bit"}, int'(bit_stb), int'(m_stb[4]));
    check({tag, " R4 byte"}, int'(byte_stb), int'(m_stb[3]));
    check({tag, " R5 frame"}, int'(frame_stb), int'(m_stb[2]));
    check({tag, " R6 pre_frame"}, int'(pre_frame_stb), int'(m_stb[1]));
    check({tag, " R7 pre_byte"}, int'(pre_byte_stb), int'(m_stb[0]));
    check({tag, " R9 mode"}, int'(tx_active), int'(m_mode));
  endtask

  // one clock: drive on falling edge, check just after the rising edge
  task automatic step(input logic en, input logic mode, input string tag);
    @(negedge clk);
    chip_en = en;
    tx_mode = mode;
    m_stb   = en ? exp_dec(m_cnt) : 5'b0;   // R8: qualified, registered
    if (en) m_cnt = (m_cnt == FRAME - 1) ? 0 : m_cnt + 1;
    m_mode  = mode;
    @(posedge clk);
    #1;
    check_all(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n   = 1'b0;
    chip_en = 1'b0;
    #1;
    m_cnt = 0; m_stb = '0; m_mode = 1'b0;
    check_all("R10 reset");
    repeat (3) begin
      @(negedge clk);
      check_all("R10 reset hold");
    end
    rst_n = 1'b1;
    // wait out the release synchroniser with the enable low
    repeat (4) step(1'b0, 1'b0, "R10 release");
  endtask

  initial begin
    rst_n = 1'b0; chip_en = 1'b0; tx_mode = 1'b0;
    void'($urandom(32'd1789));
    do_reset();

    // directed: enable always on through two wraps, mode fixed
    for (int i = 0; i < 2 * FRAME + 10; i++) step(1'b1, 1'b1, "dense");

    // directed: toggle mode every cycle around the wrap (R9)
    while (m_cnt != FRAME - 4) step(1'b1, 1'b0, "seek");
    for (int i = 0; i < 10; i++) step(1'b1, logic'(i[0]), "R9 toggle wrap");

    // directed: enable gaps right at byte and frame edges (R2, R8)
    while (m_cnt != 63) step(1'b1, 1'b0, "seek2");
    step(1'b0, 1'b1, "R2 gap before byte");
    step(1'b0, 1'b0, "R2 gap before byte");
    step(1'b1, 1'b1, "R7 after gap");
    step(1'b1, 1'b1, "R4 after gap");

    // random density phases
    for (int ph = 0; ph < 4; ph++) begin
      int pct;
      pct = (ph == 0) ? 20 : (ph == 1) ? 50 : (ph == 2) ? 90 : 100;
      for (int i = 0; i < 4000; i++) begin
        logic en, md;
        en = (($urandom % 100) < pct);
        md = (($urandom % 8) == 0) ? ~m_mode : m_mode;
        step(en, md, "random");
      end
    end

    // mid-run asynchronous reset (R10)
    do_reset();
    for (int i = 0; i < 200; i++) step(1'b1, 1'b0, "after reset");

    done = 1'b1;
  end

  // watchdog
  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule